// File: doc/BRIEF.md
# Auto-Detecting Serial Register Port

This block is a slave port that lets a host controller read and write eight 8-bit registers over a short serial link. A register file sits behind it. The port samples chip select, serial clock and both data pins with the system clock, and it offers a simple strobe bus to the register file.

The port supports two host conventions and picks one on every transaction. It looks at the level of the serial clock at the moment chip select goes low. If the clock is high, the port works LSB first and uses one bidirectional data pin. If the clock is low, the port works MSB first with separate input and output pins, which is the timing of SPI mode 0.

Each transaction has two bytes. The first byte carries the command and the address, and the second byte carries the data. The port is half duplex. The host latches bits on rising clock edges, and the port changes its output on falling edges.

Top module: `dual_mode_ctrl_port`

## Requirements
- R1: After reset, `data1_oe`, `reg_wr_o` and `reg_rd_o` are all low.
- R2: The port takes the mode from the level of `sclk_i` when `cs_n_i` falls.
  - A high level selects LSB-first mode. In this mode bits are received on `data1_i` and `data2_i` is ignored.
  - A low level selects MSB-first mode. In this mode bits are received on `data2_i`, `data1_i` is ignored, and data is sent on `data1_o`.
- R3: The port receives bits on rising `sclk_i` edges.
  - The first bit received is the read flag, where 1 means read.
  - In MSB-first mode the next three bits are address bits 2, 1 and 0, in that order.
  - In LSB-first mode the next three bits are address bits 0, 1 and 2, in that order.
  - The last four bits of the command byte have no effect.
- R4: On a write command, the data byte is assembled in the bit order of the mode. The port then gives exactly one `reg_wr_o` pulse, with that byte on `reg_wdata_o` and the decoded address on `reg_addr_o`. The pulse comes only after the 16th rising clock edge.
- R5: If `cs_n_i` rises before the 16th rising edge, no write takes place. This includes a rise that is sampled together with that edge. The register keeps its old value.
- R6: On a read command, the port gives one `reg_rd_o` pulse after the 8th rising edge, with the address held on `reg_addr_o`.
  - The byte on `reg_rdata_i` is shifted out on `data1_o`. Each bit changes on a falling edge, starting with the falling edge after the 8th rising edge.
  - In MSB-first mode bit 7 goes out first. In LSB-first mode bit 0 goes out first.
- R7: During a read, bits that arrive on the receive pin in the data phase cause no write.
- R8: `data1_oe` goes low within a few system clocks after `cs_n_i` rises, and it stays low while `cs_n_i` is high.
  - In LSB-first mode, `data1_oe` is high only in the data phase of a read.
  - In MSB-first mode, `data1_oe` is high for the whole selected transfer.
- R9: Clock edges after the 16th edge of a selection are ignored. They cause no further write or read. A new command needs `cs_n_i` to go high and then low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all port pins are sampled with it |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Active-low select from the host |
| sclk_i | input | 1 | Serial clock from the host |
| data1_i | input | 1 | Receive side of the shared data pin (LSB-first mode) |
| data1_o | output | 1 | Transmit value for the shared data pin |
| data1_oe | output | 1 | Drive enable for the shared data pin |
| data2_i | input | 1 | Receive-only data pin (MSB-first mode) |
| reg_wr_o | output | 1 | One-cycle register write strobe |
| reg_rd_o | output | 1 | One-cycle register read strobe |
| reg_addr_o | output | ADDR_W | Register address |
| reg_wdata_o | output | DATA_W | Register write data |
| reg_rdata_i | input | DATA_W | Register read data, valid in the `reg_rd_o` cycle |

## Verification
Two events can land in the same system clock cycle: the release of chip select and the 16th rising clock edge that would commit a write. The bench provokes this by raising `cs_n_i` and `sclk_i` at the same instant, so both reach the synchronizer together. It then judges the result by the absence of a write strobe and by a read-back that returns the old register value.

The bench also runs transfers that it cuts off at random points and transfers that carry extra clocks. It checks the write count against the count its own model expects.

// File: rtl/scp_pkg.sv
package scp_pkg;
   typedef enum logic {
      ORD_MSB_FIRST = 1'b0,
      ORD_LSB_FIRST = 1'b1
   } bit_order_e;
endpackage

// File: rtl/scp_sync_bank.sv
module scp_sync_bank #(
   parameter int WIDTH = 4,
   parameter int STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("scp_sync_bank: STAGES must be at least 2");
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= {STAGES{RST_VAL[b]}};
         else        chain_q <= {chain_q[STAGES-2:0], d_i[b]};
      end
      assign q_o[b] = chain_q[STAGES-1];
   end
endmodule

// File: rtl/scp_edges.sv
module scp_edges (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n_s_i,
   input  logic sclk_s_i,
   output logic cs_fall_o,
   output logic sclk_rise_o,
   output logic sclk_fall_o
);
   logic cs_prev_q;
   logic sclk_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_prev_q   <= 1'b1;
         sclk_prev_q <= 1'b0;
      end else begin
         cs_prev_q   <= cs_n_s_i;
         sclk_prev_q <= sclk_s_i;
      end
   end

   assign cs_fall_o   = cs_prev_q & ~cs_n_s_i;
   assign sclk_rise_o = ~sclk_prev_q & sclk_s_i;
   assign sclk_fall_o = sclk_prev_q & ~sclk_s_i;
endmodule

// File: rtl/scp_frame_ctl.sv
module scp_frame_ctl
   import scp_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 3,
   localparam int BITS  = 2 * DATA_W,
   localparam int CNT_W = $clog2(BITS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n_s_i,
   input  logic              cs_fall_i,
   input  logic              sclk_s_i,
   input  logic              sclk_rise_i,
   input  logic              rx_lsb_i,
   input  logic              rx_msb_i,
   output logic              active_o,
   output bit_order_e        order_o,
   output logic [CNT_W-1:0]  cnt_o,
   output logic              rw_o,
   output logic              rd_stb_o,
   output logic              wr_stb_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] wdata_o
);
   localparam logic [CNT_W-1:0] BITS_C     = CNT_W'(BITS);
   localparam logic [CNT_W-1:0] CMD_LAST_C = CNT_W'(DATA_W - 1);
   localparam logic [CNT_W-1:0] DAT_LAST_C = CNT_W'(BITS - 1);

   logic              active_q;
   bit_order_e        order_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [DATA_W-1:0] sh_q;
   logic              cmd_evt_q;
   logic              rw_q;
   logic [ADDR_W-1:0] addr_q;
   logic              rd_stb_q;
   logic              wr_stb_q;
   logic [DATA_W-1:0] wdata_q;

   logic              rx_bit;
   logic [DATA_W-1:0] sh_nxt;
   logic              take;
   logic              rw_dec;
   logic [ADDR_W-1:0] addr_dec;

   always_comb begin
      rx_bit = (order_q == ORD_LSB_FIRST) ? rx_lsb_i : rx_msb_i;
      if (order_q == ORD_LSB_FIRST) begin
         sh_nxt   = {rx_bit, sh_q[DATA_W-1:1]};
         rw_dec   = sh_q[0];
         addr_dec = sh_q[ADDR_W:1];
      end else begin
         sh_nxt   = {sh_q[DATA_W-2:0], rx_bit};
         rw_dec   = sh_q[DATA_W-1];
         addr_dec = sh_q[DATA_W-2 -: ADDR_W];
      end
      take = active_q && !cs_n_s_i && sclk_rise_i && (cnt_q != BITS_C);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q  <= 1'b0;
         order_q   <= ORD_MSB_FIRST;
         cnt_q     <= '0;
         sh_q      <= '0;
         cmd_evt_q <= 1'b0;
         rw_q      <= 1'b0;
         addr_q    <= '0;
         rd_stb_q  <= 1'b0;
         wr_stb_q  <= 1'b0;
         wdata_q   <= '0;
      end else begin
         cmd_evt_q <= 1'b0;
         rd_stb_q  <= 1'b0;
         wr_stb_q  <= 1'b0;
         if (cs_fall_i) begin
            active_q <= 1'b1;
            order_q  <= bit_order_e'(sclk_s_i);
            cnt_q    <= '0;
         end else if (cs_n_s_i) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
         end else begin
            if (take) begin
               sh_q  <= sh_nxt;
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == CMD_LAST_C) cmd_evt_q <= 1'b1;
               if (cnt_q == DAT_LAST_C && !rw_q) begin
                  wr_stb_q <= 1'b1;
                  wdata_q  <= sh_nxt;
               end
            end
            if (cmd_evt_q) begin
               rw_q     <= rw_dec;
               addr_q   <= addr_dec;
               rd_stb_q <= rw_dec;
            end
         end
      end
   end

   assign active_o = active_q;
   assign order_o  = order_q;
   assign cnt_o    = cnt_q;
   assign rw_o     = rw_q;
   assign rd_stb_o = rd_stb_q;
   assign wr_stb_o = wr_stb_q;
   assign addr_o   = addr_q;
   assign wdata_o  = wdata_q;
endmodule

// File: rtl/scp_tx_path.sv
module scp_tx_path
   import scp_pkg::*;
#(
   parameter int DATA_W         = 8,
   parameter bit FULL_DRIVE_MSB = 1'b1,
   localparam int BITS  = 2 * DATA_W,
   localparam int CNT_W = $clog2(BITS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active_i,
   input  logic              cs_n_s_i,
   input  bit_order_e        order_i,
   input  logic              rw_i,
   input  logic              load_i,
   input  logic [DATA_W-1:0] rdata_i,
   input  logic              sclk_fall_i,
   input  logic [CNT_W-1:0]  cnt_i,
   output logic              data_o,
   output logic              oe_o
);
   localparam logic [CNT_W-1:0] DW_C   = CNT_W'(DATA_W);
   localparam logic [CNT_W-1:0] BITS_C = CNT_W'(BITS);

   logic [DATA_W-1:0] tx_sh_q;
   logic              out_q;
   logic              rd_drive_q;
   logic              shift_win;
   logic              live;

   assign live      = active_i && !cs_n_s_i;
   assign shift_win = live && sclk_fall_i && (cnt_i >= DW_C) && (cnt_i < BITS_C);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sh_q    <= '0;
         out_q      <= 1'b0;
         rd_drive_q <= 1'b0;
      end else if (!live) begin
         out_q      <= 1'b0;
         rd_drive_q <= 1'b0;
      end else if (load_i) begin
         tx_sh_q <= rdata_i;
      end else if (shift_win) begin
         if (order_i == ORD_LSB_FIRST) begin
            out_q   <= tx_sh_q[0];
            tx_sh_q <= {1'b0, tx_sh_q[DATA_W-1:1]};
         end else begin
            out_q   <= tx_sh_q[DATA_W-1];
            tx_sh_q <= {tx_sh_q[DATA_W-2:0], 1'b0};
         end
         if (rw_i) rd_drive_q <= 1'b1;
      end
   end

   if (FULL_DRIVE_MSB) begin : g_full_msb
      assign oe_o = live && ((order_i == ORD_MSB_FIRST) || rd_drive_q);
   end else begin : g_read_only
      assign oe_o = live && rd_drive_q;
   end

   assign data_o = out_q;
endmodule

// File: rtl/dual_mode_ctrl_port.sv
module dual_mode_ctrl_port
   import scp_pkg::*;
#(
   parameter int DATA_W         = 8,
   parameter int ADDR_W         = 3,
   parameter int SYNC_STAGES    = 2,
   parameter bit FULL_DRIVE_MSB = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n_i,
   input  logic              sclk_i,
   input  logic              data1_i,
   output logic              data1_o,
   output logic              data1_oe,
   input  logic              data2_i,
   output logic              reg_wr_o,
   output logic              reg_rd_o,
   output logic [ADDR_W-1:0] reg_addr_o,
   output logic [DATA_W-1:0] reg_wdata_o,
   input  logic [DATA_W-1:0] reg_rdata_i
);
   localparam int BITS  = 2 * DATA_W;
   localparam int CNT_W = $clog2(BITS + 1);

   if (DATA_W < 2) begin : g_bad_data
      $error("dual_mode_ctrl_port: DATA_W must be at least 2");
   end
   if (ADDR_W + 1 > DATA_W) begin : g_bad_addr
      $error("dual_mode_ctrl_port: command byte too narrow for ADDR_W");
   end

   logic [3:0]        pins_s;
   logic              cs_n_s, sclk_s, d1_s, d2_s;
   logic              cs_fall, sclk_rise, sclk_fall;
   logic              active;
   bit_order_e        order_q;
   logic [CNT_W-1:0]  bit_cnt;
   logic              rw;
   logic              rd_stb;

   scp_sync_bank #(
      .WIDTH  (4),
      .STAGES (SYNC_STAGES),
      .RST_VAL(4'b1000)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  ({cs_n_i, sclk_i, data1_i, data2_i}),
      .q_o  (pins_s)
   );
   assign {cs_n_s, sclk_s, d1_s, d2_s} = pins_s;

   scp_edges u_edges (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_n_s_i   (cs_n_s),
      .sclk_s_i   (sclk_s),
      .cs_fall_o  (cs_fall),
      .sclk_rise_o(sclk_rise),
      .sclk_fall_o(sclk_fall)
   );

   scp_frame_ctl #(
      .DATA_W(DATA_W),
      .ADDR_W(ADDR_W)
   ) u_frame (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_n_s_i   (cs_n_s),
      .cs_fall_i  (cs_fall),
      .sclk_s_i   (sclk_s),
      .sclk_rise_i(sclk_rise),
      .rx_lsb_i   (d1_s),
      .rx_msb_i   (d2_s),
      .active_o   (active),
      .order_o    (order_q),
      .cnt_o      (bit_cnt),
      .rw_o       (rw),
      .rd_stb_o   (rd_stb),
      .wr_stb_o   (reg_wr_o),
      .addr_o     (reg_addr_o),
      .wdata_o    (reg_wdata_o)
   );

   scp_tx_path #(
      .DATA_W        (DATA_W),
      .FULL_DRIVE_MSB(FULL_DRIVE_MSB)
   ) u_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .active_i   (active),
      .cs_n_s_i   (cs_n_s),
      .order_i    (order_q),
      .rw_i       (rw),
      .load_i     (rd_stb),
      .rdata_i    (reg_rdata_i),
      .sclk_fall_i(sclk_fall),
      .cnt_i      (bit_cnt),
      .data_o     (data1_o),
      .oe_o       (data1_oe)
   );

   assign reg_rd_o = rd_stb;
endmodule

// File: rtl/dual_mode_ctrl_port_chk.sv
module dual_mode_ctrl_port_chk #(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 3,
   parameter int SYNC_STAGES = 2,
   localparam int BITS  = 2 * DATA_W,
   localparam int CNT_W = $clog2(BITS + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_n_i,
   input logic              data1_oe,
   input logic              reg_wr_o,
   input logic              reg_rd_o,
   input logic [ADDR_W-1:0] reg_addr_o,
   input logic [CNT_W-1:0]  bit_cnt,
   input logic              lsb_first
);
   localparam int LIM = SYNC_STAGES + 2;
   localparam int HW  = $clog2(LIM + 1);
   localparam logic [HW-1:0]    LIM_C  = HW'(LIM);
   localparam logic [CNT_W-1:0] BITS_C = CNT_W'(BITS);
   localparam logic [CNT_W-1:0] DW_C   = CNT_W'(DATA_W);

   logic [HW-1:0] hi_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          hi_cnt <= '0;
      else if (!cs_n_i)    hi_cnt <= '0;
      else if (hi_cnt != LIM_C) hi_cnt <= hi_cnt + 1'b1;
   end

   AST_WR_RD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr_o && reg_rd_o)); // R4
   AST_WR_AFTER_LAST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_o |-> (bit_cnt == BITS_C)); // R4
   AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_o |=> !reg_wr_o); // R9
   AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd_o |=> !reg_rd_o); // R6
   AST_RD_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd_o |-> (bit_cnt >= DW_C)); // R6
   AST_RD_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd_o |=> $stable(reg_addr_o)); // R6
   AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_cnt == LIM_C) |-> !data1_oe); // R8
   AST_LSB_CMD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (lsb_first && (bit_cnt < DW_C)) |-> !data1_oe); // R8
endmodule

bind dual_mode_ctrl_port dual_mode_ctrl_port_chk #(
   .DATA_W     (DATA_W),
   .ADDR_W     (ADDR_W),
   .SYNC_STAGES(SYNC_STAGES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cs_n_i    (cs_n_i),
   .data1_oe  (data1_oe),
   .reg_wr_o  (reg_wr_o),
   .reg_rd_o  (reg_rd_o),
   .reg_addr_o(reg_addr_o),
   .bit_cnt   (bit_cnt),
   .lsb_first (order_q == scp_pkg::ORD_LSB_FIRST)
);

// File: tb/dual_mode_ctrl_port_tb_top.sv
`timescale 1ns/1ps
module dual_mode_ctrl_port_tb_top;
   localparam int H = 10;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       cs_n, sclk, d1_host, d2_host;
   logic       data1_o, data1_oe;
   logic       reg_wr, reg_rd;
   logic [2:0] reg_addr;
   logic [7:0] reg_wdata, reg_rdata;

   always #2.5 clk = ~clk;

   dual_mode_ctrl_port dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_n_i     (cs_n),
      .sclk_i     (sclk),
      .data1_i    (d1_host),
      .data1_o    (data1_o),
      .data1_oe   (data1_oe),
      .data2_i    (d2_host),
      .reg_wr_o   (reg_wr),
      .reg_rd_o   (reg_rd),
      .reg_addr_o (reg_addr),
      .reg_wdata_o(reg_wdata),
      .reg_rdata_i(reg_rdata)
   );

   logic [7:0] rf [8];
   logic [7:0] exp_rf [8];
   int         wr_cnt, rd_cnt;
   logic [2:0] last_waddr;
   logic [7:0] last_wdata;
   int         n_chk = 0, n_err = 0;
   bit         done = 1'b0;

   assign reg_rdata = rf[reg_addr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 8; i++) rf[i] <= 8'h30 + 8'(i);
         wr_cnt <= 0;
         rd_cnt <= 0;
         last_waddr <= '0;
         last_wdata <= '0;
      end else begin
         if (reg_wr) begin
            rf[reg_addr] <= reg_wdata;
            wr_cnt       <= wr_cnt + 1;
            last_waddr   <= reg_addr;
            last_wdata   <= reg_wdata;
         end
         if (reg_rd) rd_cnt <= rd_cnt + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic frame_bit(input bit lsb, input bit rd, input logic [2:0] addr,
                                      input logic [3:0] unused, input logic [7:0] wd, input int i);
      if (i == 0) return rd;
      if (i < 4)  return lsb ? addr[i-1] : addr[3-i];
      if (i < 8)  return unused[i-4];
      if (i < 16) return lsb ? wd[i-8] : wd[15-i];
      return 1'($urandom);
   endfunction

   task automatic do_xfer(input bit lsb, input bit rd, input logic [2:0] addr,
                          input logic [7:0] wd, input int nbits, input bit cs_on_last,
                          output logic [7:0] got, output bit oe_bad);
      logic [3:0] unused;
      logic       b;
      unused = 4'($urandom);
      got    = '0;
      oe_bad = 1'b0;
      sclk = lsb;
      cs_n = 1'b1;
      wait_cyc(H);
      cs_n = 1'b0;
      wait_cyc(H);
      for (int i = 0; i < nbits; i++) begin
         b = frame_bit(lsb, rd, addr, unused, wd, i);
         if (lsb) begin
            sclk = 1'b0;
            d1_host = b;
            d2_host = ~b;
            wait_cyc(H);
            if (rd && i >= 8 && i < 16) begin
               if (!data1_oe) oe_bad = 1'b1;
               got[i-8] = data1_o;
            end
            if ((i < 8 || !rd) && data1_oe) oe_bad = 1'b1;
            if (cs_on_last && i == nbits - 1) cs_n = 1'b1;
            sclk = 1'b1;
            wait_cyc(H);
         end else begin
            d2_host = b;
            d1_host = ~b;
            wait_cyc(H);
            if (!data1_oe) oe_bad = 1'b1;
            if (rd && i >= 8 && i < 16) got[15-i] = data1_o;
            if (cs_on_last && i == nbits - 1) cs_n = 1'b1;
            sclk = 1'b1;
            wait_cyc(H);
            sclk = 1'b0;
         end
      end
      if (!cs_on_last) begin
         wait_cyc(H);
         cs_n = 1'b1;
      end
      wait_cyc(2 * H);
   endtask

   task automatic run(input bit lsb, input bit rd, input logic [2:0] addr,
                      input logic [7:0] wd, input int nbits, input bit cs_on_last,
                      input string tag);
      int         wr0, rd0, exp_wr, exp_rd;
      logic [7:0] got;
      bit         oe_bad;
      string      wtag;
      wr0 = wr_cnt;
      rd0 = rd_cnt;
      do_xfer(lsb, rd, addr, wd, nbits, cs_on_last, got, oe_bad);
      exp_wr = (!rd && nbits >= 16 && !cs_on_last) ? 1 : 0;
      exp_rd = (rd && nbits >= 8) ? 1 : 0;
      if (rd)                             wtag = "R7";
      else if (nbits < 16 || cs_on_last)  wtag = "R5";
      else if (nbits > 16)                wtag = "R9";
      else                                wtag = "R4";
      chk(wr_cnt - wr0 == exp_wr, wtag, "write count", 32'(wr_cnt - wr0), 32'(exp_wr));
      chk(rd_cnt - rd0 == exp_rd, nbits > 16 ? "R9" : "R6", "read count",
          32'(rd_cnt - rd0), 32'(exp_rd));
      if (exp_wr == 1 && wr_cnt - wr0 == 1) begin
         chk(last_waddr == addr, tag, "write address", 32'(last_waddr), 32'(addr));
         chk(last_wdata == wd, tag, "write data", 32'(last_wdata), 32'(wd));
      end
      if (exp_wr == 1) exp_rf[addr] = wd;
      if (rd && nbits >= 16)
         chk(got == exp_rf[addr], tag, "read data", 32'(got), 32'(exp_rf[addr]));
      chk(!oe_bad, "R8", "drive window", 32'(oe_bad), 32'd0);
      chk(!data1_oe, "R8", "released after select", 32'(data1_oe), 32'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog (all) actual=timeout expected=completion");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd24681357));
      for (int i = 0; i < 8; i++) exp_rf[i] = 8'h30 + 8'(i);
      rst_n = 1'b0;
      cs_n = 1'b1;
      sclk = 1'b0;
      d1_host = 1'b0;
      d2_host = 1'b0;
      wait_cyc(5);
      chk(!data1_oe && !reg_wr && !reg_rd, "R1", "outputs in reset",
          {29'd0, data1_oe, reg_wr, reg_rd}, 32'd0);
      rst_n = 1'b1;
      wait_cyc(5);
      chk(!data1_oe && !reg_wr && !reg_rd, "R1", "outputs after reset",
          {29'd0, data1_oe, reg_wr, reg_rd}, 32'd0);

      // R2 R3 R4 R6: MSB-first write and read, asymmetric addresses
      run(1'b0, 1'b0, 3'd6, 8'hA5, 16, 1'b0, "R4");
      run(1'b0, 1'b1, 3'd6, 8'h00, 16, 1'b0, "R6");
      run(1'b0, 1'b1, 3'd3, 8'h00, 16, 1'b0, "R3");
      // R2 R3: LSB-first write, readback in both modes
      run(1'b1, 1'b0, 3'd1, 8'h4D, 16, 1'b0, "R2");
      run(1'b1, 1'b1, 3'd1, 8'h00, 16, 1'b0, "R2");
      run(1'b0, 1'b1, 3'd1, 8'h00, 16, 1'b0, "R3");
      run(1'b1, 1'b1, 3'd4, 8'h00, 16, 1'b0, "R3");
      // R5: early release, and release together with the last edge
      run(1'b0, 1'b0, 3'd2, 8'hEE, 12, 1'b0, "R5");
      run(1'b0, 1'b1, 3'd2, 8'h00, 16, 1'b0, "R5");
      run(1'b1, 1'b0, 3'd2, 8'h11, 16, 1'b1, "R5");
      run(1'b0, 1'b0, 3'd2, 8'h22, 16, 1'b1, "R5");
      run(1'b1, 1'b1, 3'd2, 8'h00, 16, 1'b0, "R5");
      // R9: extra clocks after the data byte
      run(1'b0, 1'b0, 3'd7, 8'h96, 24, 1'b0, "R9");
      run(1'b1, 1'b0, 3'd0, 8'h3C, 21, 1'b0, "R9");
      run(1'b1, 1'b1, 3'd7, 8'h00, 24, 1'b0, "R9");
      run(1'b0, 1'b1, 3'd0, 8'h00, 16, 1'b0, "R9");

      for (int k = 0; k < 40; k++) begin
         bit         lsb, rd, col;
         int         sel, nb;
         logic [2:0] a;
         logic [7:0] w;
         lsb = 1'($urandom);
         rd  = 1'($urandom);
         a   = 3'($urandom);
         w   = 8'($urandom);
         sel = int'($urandom % 8);
         nb  = (sel == 0) ? 9 + int'($urandom % 7) : (sel == 1) ? 17 + int'($urandom % 8) : 16;
         col = (sel == 2) && !rd;
         run(lsb, rd, a, w, nb, col, rd ? "R6" : "R4");
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule